// File: doc/BRIEF.md
# Multi-Mode Up/Down Event Counter

This block is a 16-bit counter that software configures through a small register interface. It has four selectable ways of counting. As a timer, it steps down once per prescaled tick. As an event counter, edges on pin A raise the count and edges on pin B lower it. As a quadrature decoder, it follows two phase-shifted signals and counts at two or four steps per cycle of the pair. A reload/compare register serves two purposes: it supplies the value loaded on underflow, and it gives the value at which the counter can optionally be cleared.

A third pin, the zero pin, can be configured in one of two ways. It can hold the counter at zero, or it can act as a gate that allows counting only while it is high. Software can load the reload value into the counter, clear the counter, and clear three sticky event flags. The event flags are underflow, overflow and compare-match. All three pins are asynchronous and pass through a two-stage synchronizer before use.

Control word layout (`ctl_wdata` / `ctl_rdata`): [9:8] count mode, [7:6] edge select, [5] spare bit, [4] load-from-reload strobe, [3] compare-clear enable, [2] reload-on-underflow enable, [1] clear strobe (active low), [0] zero-pin role.

Top module: `udc_core`

## Requirements
- R1: After reset, `count`, `rld_rdata` and `flags` are zero, and `ctl_rdata` reads 10'h002.
- R2: In mode 00 (timer), the count falls by one on each clock where `run` and `tick` are both high. Pins A and B have no effect in this mode.
- R3: In mode 01 (up/down), edge select 00 counts nothing, 01 counts falling edges, 10 counts rising edges and 11 counts both. A selected edge on A adds one and a selected edge on B subtracts one. If both occur in the same cycle, there is no change.
- R4: In mode 10 (x2 quadrature), the count changes on each edge of A, and the edge select field is ignored. The phase sequence {A,B} = 00,10,11,01 counts up, and the reverse sequence counts down.
- R5: In mode 11 (x4 quadrature), every single-phase transition of that sequence changes the count by one in the direction of travel.
- R6: A down step from 0 sets flags[0]. The counter then becomes 16'hFFFF when reload (bit 2) is off, or takes the reload value when reload is on.
- R7: An up step from 16'hFFFF wraps the counter to 0 and sets flags[1].
- R8: A non-underflow step whose result equals the reload value sets flags[2]. The counter is forced to 0 only when bit 3 is set.
- R9: A control write with bit 4 = 1 copies the reload value into the counter. With bit 4 = 0, the counter is left unchanged.
- R10: A control write with bit 1 = 0 clears the counter, and this takes priority over a load. Bit 1 = 1 has no effect.
- R11: With bit 0 = 0, a high zero pin holds the counter at 0, whatever bit 3 is. With bit 0 = 1, counting happens only while the zero pin is high, and the pin never clears.
- R12: The flags are sticky. A status write with a 0 in a bit position clears that flag, and a 1 leaves it unchanged.
- R13: The spare control bit 5 reads back as last written. Bit 4 reads 0 and bit 1 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counting enable |
| tick | input | 1 | Prescaled timer strobe |
| pin_a | input | 1 | Phase A / up event pin |
| pin_b | input | 1 | Phase B / down event pin |
| pin_z | input | 1 | Zero pin (clear or gate) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 10 | Control write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| sts_we | input | 1 | Flag write strobe |
| sts_wdata | input | 3 | Flag write data, 0 clears |
| count | output | 16 | Counter value |
| rld_rdata | output | 16 | Reload/compare value |
| ctl_rdata | output | 10 | Control readback |
| flags | output | 3 | {compare, overflow, underflow} |

## Verification
The hardest state to reach from the ports is a quadrature walk that reverses direction at arbitrary points. Such a walk only shows a direction error after the count has drifted. The stimulus therefore drives long random forward/backward walks through the Gray sequence in both x2 and x4 modes, with the expected count tracked by a phase-index model. Directed runs add a walk across the 16'hFFFF/0 boundary, a compare hit with clearing on and off, and gate or clear activity on the zero pin with quadrature steps arriving while the gate is closed.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_UPDN  = 2'b01,
        MODE_QX2   = 2'b10,
        MODE_QX4   = 2'b11
    } udc_mode_e;

    typedef struct packed {
        udc_mode_e  mode;
        logic [1:0] esel;
        logic       spare;
        logic       cmpclr;
        logic       rlden;
        logic       zgate;
    } udc_ctl_t;

    localparam int CTL_W      = 10;
    localparam int B_MODE     = 8;
    localparam int B_ESEL     = 6;
    localparam int B_SPARE    = 5;
    localparam int B_XFER     = 4;
    localparam int B_CMPCLR   = 3;
    localparam int B_RLDEN    = 2;
    localparam int B_CLRN     = 1;
    localparam int B_ZGATE    = 0;
    localparam int FLAG_UF    = 0;
    localparam int FLAG_OF    = 1;
    localparam int FLAG_CM    = 2;
    localparam int NFLAGS     = 3;

    function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
        case (sel)
            2'b01:   return prev & ~cur;
            2'b10:   return ~prev & cur;
            2'b11:   return prev ^ cur;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/udc_step.sv
module udc_step
    import udc_pkg::*;
(
    input  udc_mode_e  mode,
    input  logic [1:0] esel,
    input  logic       a_p,
    input  logic       a_s,
    input  logic       b_p,
    input  logic       b_s,
    input  logic       tick,
    input  logic       en,
    output logic       up,
    output logic       dn
);
    logic a_chg, b_chg, fwd, ea, eb;

    always_comb begin
        a_chg = a_p ^ a_s;
        b_chg = b_p ^ b_s;
        // For a single-phase move, forward travel iff new A differs from old B
        fwd   = a_s ^ b_p;
        ea    = edge_hit(esel, a_p, a_s);
        eb    = edge_hit(esel, b_p, b_s);
        up    = 1'b0;
        dn    = 1'b0;
        case (mode)
            MODE_TIMER: dn = tick;
            MODE_UPDN: begin
                up = ea & ~eb;
                dn = eb & ~ea;
            end
            MODE_QX2: begin
                up = a_chg & ~b_chg & fwd;
                dn = a_chg & ~b_chg & ~fwd;
            end
            default: begin
                up = (a_chg ^ b_chg) & fwd;
                dn = (a_chg ^ b_chg) & ~fwd;
            end
        endcase
        up = up & en;
        dn = dn & en;
    end
endmodule

// File: rtl/udc_core.sv
module udc_core
    import udc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_z,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              rld_we,
    input  logic [W-1:0]      rld_wdata,
    input  logic              sts_we,
    input  logic [NFLAGS-1:0] sts_wdata,
    output logic [W-1:0]      count,
    output logic [W-1:0]      rld_rdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [NFLAGS-1:0] flags
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0]      cnt;
        logic [W-1:0]      rld;
        udc_ctl_t          ctl;
        logic [NFLAGS-1:0] flg;
        logic              ap;
        logic              bp;
    } state_t;

    state_t state_d, state_q;
    logic   a_s, b_s, z_s;
    logic   step_up, step_dn, step_en;
    logic [W-1:0] stepped;

    udc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_a, pin_b, pin_z}),
        .q     ({a_s, b_s, z_s})
    );

    assign step_en = run & (~state_q.ctl.zgate | z_s);

    udc_step u_step (
        .mode (state_q.ctl.mode),
        .esel (state_q.ctl.esel),
        .a_p  (state_q.ap),
        .a_s  (a_s),
        .b_p  (state_q.bp),
        .b_s  (b_s),
        .tick (tick),
        .en   (step_en),
        .up   (step_up),
        .dn   (step_dn)
    );

    always_comb begin
        state_d    = state_q;
        stepped    = state_q.cnt;
        state_d.ap = a_s;
        state_d.bp = b_s;

        if (sts_we) state_d.flg = state_q.flg & sts_wdata;
        if (rld_we) state_d.rld = rld_wdata;
        if (ctl_we) begin
            state_d.ctl.mode   = udc_mode_e'(ctl_wdata[B_MODE +: 2]);
            state_d.ctl.esel   = ctl_wdata[B_ESEL +: 2];
            state_d.ctl.spare  = ctl_wdata[B_SPARE];
            state_d.ctl.cmpclr = ctl_wdata[B_CMPCLR];
            state_d.ctl.rlden  = ctl_wdata[B_RLDEN];
            state_d.ctl.zgate  = ctl_wdata[B_ZGATE];
        end

        if (ctl_we && !ctl_wdata[B_CLRN]) begin
            state_d.cnt = '0;
        end else if (ctl_we && ctl_wdata[B_XFER]) begin
            state_d.cnt = state_q.rld;
        end else if (!state_q.ctl.zgate && z_s) begin
            state_d.cnt = '0;
        end else if (step_dn && state_q.cnt == '0) begin
            state_d.flg[FLAG_UF] = 1'b1;
            state_d.cnt = state_q.ctl.rlden ? state_q.rld : CNT_MAX;
        end else if (step_up || step_dn) begin
            stepped = step_up ? state_q.cnt + 1'b1 : state_q.cnt - 1'b1;
            if (step_up && state_q.cnt == CNT_MAX) state_d.flg[FLAG_OF] = 1'b1;
            state_d.cnt = stepped;
            if (stepped == state_q.rld) begin
                state_d.flg[FLAG_CM] = 1'b1;
                if (state_q.ctl.cmpclr) state_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count     = state_q.cnt;
    assign rld_rdata = state_q.rld;
    assign flags     = state_q.flg;
    assign ctl_rdata = {state_q.ctl.mode, state_q.ctl.esel, state_q.ctl.spare,
                        1'b0, state_q.ctl.cmpclr, state_q.ctl.rlden, 1'b1,
                        state_q.ctl.zgate};
endmodule

// File: rtl/udc_core_chk.sv
module udc_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_we,
    input logic         w_clrn,
    input logic         w_xfer,
    input logic         sts_we,
    input logic [1:0]   mode,
    input logic         zgate,
    input logic         z_sync,
    input logic         uf_flag,
    input logic [W-1:0] count,
    input logic [W-1:0] rld
);
    // R10: clear strobe zeroes the counter on the next cycle
    p_swclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !w_clrn) |=> (count == '0));

    // R9: load strobe copies the reload value held before the write
    p_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && w_clrn && w_xfer) |=> (count == $past(rld)));

    // R11: zero pin as clear
    p_zclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !zgate && z_sync) |=> (count == '0));

    // R11: zero pin as gate holds the value while low
    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && zgate && !z_sync) |=> (count == $past(count)));

    // R2: timer mode never steps upward
    p_timer_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && mode == 2'b00) |=>
        (count == $past(count) || count == $past(count) - 1'b1 ||
         count == $past(rld) || count == '0 || count == '1));

    // R12: underflow flag is sticky without a status write
    p_uf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !sts_we) |=> uf_flag);
endmodule

bind udc_core udc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (ctl_we),
    .w_clrn  (ctl_wdata[1]),
    .w_xfer  (ctl_wdata[4]),
    .sts_we  (sts_we),
    .mode    (ctl_rdata[9:8]),
    .zgate   (ctl_rdata[0]),
    .z_sync  (z_s),
    .uf_flag (flags[0]),
    .count   (count),
    .rld     (rld_rdata)
);

// File: tb/udc_core_bench.sv
`timescale 1ns/1ps
module udc_core_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, run = 1'b0, tick = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0, pin_z = 1'b0;
    logic        ctl_we = 1'b0, rld_we = 1'b0, sts_we = 1'b0;
    logic [9:0]  ctl_wdata = '0;
    logic [15:0] rld_wdata = '0;
    logic [2:0]  sts_wdata = '0;
    logic [15:0] count, rld_rdata;
    logic [9:0]  ctl_rdata;
    logic [2:0]  flags;

    int total = 0, bad = 0;
    int gi = 0;
    logic [15:0] exp_cnt;
    logic [1:0] gseq [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

    udc_core u_udc_core (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] mk(input logic [1:0] m, input logic [1:0] e, input logic sp,
                                      input logic xf, input logic cc, input logic rl,
                                      input logic cn, input logic zg);
        return {m, e, sp, xf, cc, rl, cn, zg};
    endfunction

    function automatic int gidx(input logic [1:0] ab);
        for (int i = 0; i < 4; i++) if (gseq[i] == ab) return i;
        return 0;
    endfunction

    function automatic int quad_delta(input bit x4, input logic [1:0] o, input logic [1:0] n);
        int d;
        d = (gidx(n) - gidx(o) + 4) % 4;
        if (!x4 && o[1] == n[1]) return 0;
        return (d == 1) ? 1 : (d == 3) ? -1 : 0;
    endfunction

    task automatic wctl(input logic [9:0] v);
        ctl_we = 1'b1; ctl_wdata = v; cyc(1); ctl_we = 1'b0;
    endtask
    task automatic wrld(input logic [15:0] v);
        rld_we = 1'b1; rld_wdata = v; cyc(1); rld_we = 1'b0;
    endtask
    task automatic wsts(input logic [2:0] v);
        sts_we = 1'b1; sts_wdata = v; cyc(1); sts_we = 1'b0;
    endtask
    task automatic tk();
        tick = 1'b1; cyc(1); tick = 1'b0;
    endtask
    task automatic pins(input logic a, input logic b);
        pin_a = a; pin_b = b; cyc(5);
    endtask
    task automatic qstep(input bit up);
        gi = up ? (gi + 1) % 4 : (gi + 3) % 4;
        pins(gseq[gi][1], gseq[gi][0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1
        chk("R1 count", count, 16'h0);
        chk("R1 flags", {13'b0, flags}, 16'h0);
        chk("R1 ctl", {6'b0, ctl_rdata}, 16'h002);
        chk("R1 rld", rld_rdata, 16'h0);
        // R13
        wctl(mk(2'b00, 2'b00, 1, 1, 0, 0, 1, 0));
        chk("R13 spare readback", {6'b0, ctl_rdata}, {6'b0, mk(2'b00, 2'b00, 1, 0, 0, 0, 1, 0)});
        wctl(mk(2'b00, 2'b00, 0, 0, 0, 0, 1, 0));
        chk("R13 spare cleared", {15'b0, ctl_rdata[5]}, 16'h0);
        // R9
        wrld(16'h1234);
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 1, 0));
        chk("R9 load", count, 16'h1234);
        wrld(16'h0777);
        wctl(mk(2'b00, 2'b00, 0, 0, 0, 0, 1, 0));
        chk("R9 no load", count, 16'h1234);
        // R2
        run = 1'b1;
        repeat (5) tk();
        chk("R2 five ticks", count, 16'h122F);
        pins(1, 0); pins(0, 0); pins(0, 1); pins(0, 0);
        chk("R2 pins ignored", count, 16'h122F);
        run = 1'b0; tk(); run = 1'b1;
        chk("R2 run low", count, 16'h122F);
        // R10
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 1, 0));
        wctl(mk(2'b00, 2'b00, 0, 0, 0, 0, 1, 0));
        chk("R10 clrn=1 no effect", count, 16'h0777);
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 0, 0));
        chk("R10 clear beats load", count, 16'h0);
        // R6 no reload
        tk();
        chk("R6 wrap", count, 16'hFFFF);
        chk("R6 uf flag", {15'b0, flags[0]}, 16'h1);
        // R12
        tk();
        chk("R12 sticky", {15'b0, flags[0]}, 16'h1);
        wsts(3'b111);
        chk("R12 write 1 keeps", {15'b0, flags[0]}, 16'h1);
        wsts(3'b110);
        chk("R12 write 0 clears", {15'b0, flags[0]}, 16'h0);
        // R6 reload
        wrld(16'h0010);
        wctl(mk(2'b00, 2'b00, 0, 0, 0, 1, 0, 0));
        tk();
        chk("R6 reload", count, 16'h0010);
        chk("R6 uf flag again", {15'b0, flags[0]}, 16'h1);
        // R8
        wsts(3'b000);
        wrld(16'h0100);
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 1, 0));
        wrld(16'h00FE);
        wctl(mk(2'b00, 2'b00, 0, 0, 1, 0, 1, 0));
        tk(); tk();
        chk("R8 compare clear", count, 16'h0);
        chk("R8 cm flag", {15'b0, flags[2]}, 16'h1);
        wsts(3'b000);
        wrld(16'h0100);
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 1, 0));
        wrld(16'h00FE);
        tk(); tk();
        chk("R8 no clear", count, 16'h00FE);
        chk("R8 cm flag w/o clear", {15'b0, flags[2]}, 16'h1);
        // R3
        wrld(16'h8000);
        wctl(mk(2'b01, 2'b10, 0, 0, 0, 0, 0, 0));
        pins(1, 0); chk("R3 rise A", count, 16'h1);
        pins(0, 0); chk("R3 fall A ignored", count, 16'h1);
        pins(0, 1); chk("R3 rise B", count, 16'h0);
        pins(0, 0);
        wctl(mk(2'b01, 2'b11, 0, 0, 0, 0, 1, 0));
        pins(1, 0); pins(0, 0); chk("R3 both edges", count, 16'h2);
        wctl(mk(2'b01, 2'b01, 0, 0, 0, 0, 1, 0));
        pins(1, 0); pins(0, 0); chk("R3 falling only", count, 16'h3);
        wctl(mk(2'b01, 2'b00, 0, 0, 0, 0, 1, 0));
        pins(1, 0); pins(0, 0); chk("R3 disabled", count, 16'h3);
        wctl(mk(2'b01, 2'b11, 0, 0, 0, 0, 1, 0));
        pins(1, 1); pins(0, 0); chk("R3 cancel", count, 16'h3);
        // R4 directed
        gi = 0;
        wctl(mk(2'b10, 2'b00, 0, 0, 0, 0, 0, 0));
        repeat (4) qstep(1);
        chk("R4 forward", count, 16'h2);
        repeat (4) qstep(0);
        chk("R4 reverse", count, 16'h0);
        // R4 / R5 random walks
        for (int m = 0; m < 2; m++) begin
            exp_cnt = 16'h0;
            wctl(mk(m ? 2'b11 : 2'b10, 2'b01, 0, 0, 0, 0, 0, 0));
            for (int i = 0; i < 150; i++) begin
                logic [1:0] o;
                o = gseq[gi];
                qstep(($urandom % 3) != 0);
                exp_cnt = exp_cnt + 16'(quad_delta(m == 1, o, gseq[gi]));
            end
            chk(m ? "R5 x4 walk" : "R4 x2 walk", count, exp_cnt);
        end
        // R7
        wrld(16'hFFFF);
        wctl(mk(2'b11, 2'b00, 0, 1, 0, 0, 1, 0));
        wsts(3'b000);
        qstep(1);
        chk("R7 wrap", count, 16'h0);
        chk("R7 of flag", {15'b0, flags[1]}, 16'h1);
        // R11
        wrld(16'h0005);
        wctl(mk(2'b11, 2'b00, 0, 1, 0, 0, 1, 0));
        pin_z = 1'b1; cyc(5);
        chk("R11 zero clear", count, 16'h0);
        pin_z = 1'b0; cyc(4);
        wctl(mk(2'b11, 2'b00, 0, 0, 0, 0, 1, 1));
        qstep(1); qstep(1);
        chk("R11 gate closed", count, 16'h0);
        pin_z = 1'b1; cyc(5);
        qstep(1);
        chk("R11 gate open no clear", count, 16'h1);
        pin_z = 1'b0;
        // R2 random timer
        wrld(16'h0003);
        wctl(mk(2'b00, 2'b00, 0, 1, 0, 0, 1, 0));
        exp_cnt = 16'h0003;
        for (int i = 0; i < 400; i++) begin
            run  = 1'($urandom % 2);
            tick = (($urandom % 3) == 0);
            if (run && tick) exp_cnt = exp_cnt - 16'h1;
            cyc(1);
            if (i % 100 == 99) chk("R2 random timer", count, exp_cnt);
        end
        tick = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule